// File: doc/BRIEF.md
# I2C Word-Wide Slave Port with Ready/Busy Pause

This block is a slave port on a two-wire I2C bus that connects an external bus master to an internal interface carrying 32-bit words. It watches the synchronized clock and data lines for start and stop conditions. It takes in a 7-bit address followed by a direction bit and answers only when the address matches its parameter. In a write, the received bytes are acknowledged and packed into words with the first byte in the most significant position. Each finished word goes to the internal side with a single-cycle strobe.

In a read, the block asks the internal side for a whole word through a request/acknowledge pair before it drives the first bit. It then shifts that word out byte by byte and continues for as long as the master acknowledges. When the internal side cannot take or give a word, the block pauses the master in two ways at once. It drives a ready line low, and it holds the clock line low until the internal side catches up. Both bus lines are open-drain. The outputs `scl_oe` and `sda_oe` mean "pull this line low".

Top module: `i2c_word_slave`

## Requirements
- R1: A start is a falling data line while the clock line is high. After a start, the block acknowledges the address byte (data pulled low during the ninth clock) when the upper seven bits of that byte equal `DEV_ADDR`. Bit 0 of the address byte is the direction: 0 = write, 1 = read.
- R2: On an address mismatch the block never pulls data or clock low, and it produces no write strobe until the next start.
- R3: Written bytes are packed first-byte-most-significant. After the fourth byte, `wr_valid` is high for exactly one cycle, and `wr_word` then holds the four bytes.
- R4: Every byte written to a matched address is acknowledged during its ninth clock.
- R5: When `wr_ready` is low as the fourth byte of a word completes, `busy_n` goes low and the clock line is held low until `wr_ready` rises. The word is then delivered and `busy_n` returns high.
- R6: Before the first bit of every read word, `rd_req` is raised and held until `rd_ack`. For that whole time `busy_n` is low and the clock line is held low. Read bits leave most significant bit first, starting at bit 31 of `rd_word`.
- R7: A read continues word after word while the master acknowledges, with one new fetch every four bytes.
- R8: A master not-acknowledge ends the read. No further fetch is made and the data line stays released.
- R9: A stop (rising data line while clock is high) ends the transfer and releases both lines. A partial word is dropped.
- R10: A repeated start resets the byte position, so the next four bytes form a fresh word.
- R11: The block changes its data-line drive only while the synchronized clock is low.
- R12: After reset both lines are released, `busy_n` is high, and `wr_valid` and `rd_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| scl_oe | output | 1 | High pulls the clock line low (stretch) |
| sda_oe | output | 1 | High pulls the data line low |
| busy_n | output | 1 | Ready line, low while paused for the internal side |
| wr_word | output | 32 | Assembled write word, valid with `wr_valid` |
| wr_valid | output | 1 | One-cycle strobe for a finished write word |
| wr_ready | input | 1 | Internal side can accept a word |
| rd_req | output | 1 | Request for the next read word |
| rd_ack | input | 1 | Internal side supplies `rd_word` this cycle |
| rd_word | input | 32 | Read word from the internal side |

## Verification
The sensitive cycle is the falling clock edge that closes the fourth byte of a write. In that cycle the byte is packed and `wr_ready` is sampled, and together they decide between an immediate strobe and a stretch. The bench takes the no-stretch path with `wr_ready` held high. It takes the stretch path by holding `wr_ready` low through the fourth byte and raising it while the bus is held, then checks the ready line, the clock line, the strobe count and the word. On the read side, accepting the fetch and setting the first data bit fall in one cycle, and the clock is released a cycle later. The master's sampled bytes and the fetch count confirm this.

// File: rtl/i2c_ws_pkg.sv
package i2c_ws_pkg;

   localparam int unsigned BYTE_W = 8;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WR_BYTE,
      ST_WR_WAIT,
      ST_WR_ACK,
      ST_RD_FETCH,
      ST_RD_BYTE,
      ST_RD_ACK,
      ST_IGNORE
   } ws_state_e;

endpackage

// File: rtl/i2c_ws_sync.sv
module i2c_ws_sync #(
   parameter int unsigned N_LINES = 2,
   parameter int unsigned STAGES  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] raw,
   output logic [N_LINES-1:0] sync,
   output logic [N_LINES-1:0] rise,
   output logic [N_LINES-1:0] fall
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_ws_sync: STAGES must be at least 2");
      end
      if (N_LINES < 1) begin : g_bad_lines
         $error("i2c_ws_sync: N_LINES must be at least 1");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < N_LINES; gi++) begin : g_line
         logic [STAGES-1:0] chain;
         logic              prev;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain <= '1;
               prev  <= 1'b1;
            end else begin
               chain <= {chain[STAGES-2:0], raw[gi]};
               prev  <= chain[STAGES-1];
            end
         end

         assign sync[gi] = chain[STAGES-1];
         assign rise[gi] = chain[STAGES-1] & ~prev;
         assign fall[gi] = ~chain[STAGES-1] & prev;
      end
   endgenerate

endmodule

// File: rtl/i2c_ws_cond.sv
module i2c_ws_cond (
   input  logic scl_s,
   input  logic sda_rise,
   input  logic sda_fall,
   output logic start_det,
   output logic stop_det
);

   // data may move only while the clock is low; a data edge with the clock
   // high is a bus condition
   assign start_det = sda_fall & scl_s;
   assign stop_det  = sda_rise & scl_s;

endmodule

// File: rtl/i2c_ws_datapath.sv
module i2c_ws_datapath
   import i2c_ws_pkg::*;
#(
   parameter int unsigned WORD_BYTES = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         bit_clr,
   input  logic                         bit_step,
   input  logic                         sda_bit,
   input  logic                         pack_en,
   input  logic                         load_en,
   input  logic [BYTE_W*WORD_BYTES-1:0] load_word,
   input  logic                         tx_shift,
   output logic [3:0]                   bit_cnt,
   output logic [BYTE_W-1:0]            rx_byte,
   output logic [BYTE_W*WORD_BYTES-1:0] asm_word,
   output logic                         tx_msb,
   output logic                         tx_nxt
);

   localparam int unsigned WORD_W = BYTE_W * WORD_BYTES;

   logic [WORD_W-1:0] tx_sh;

   // bit counter and receive shifter: one step per rising clock
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         rx_byte <= '0;
      end else begin
         if (bit_clr) begin
            bit_cnt <= '0;
         end else if (bit_step) begin
            bit_cnt <= bit_cnt + 4'd1;
         end
         if (bit_step) begin
            rx_byte <= {rx_byte[BYTE_W-2:0], sda_bit};
         end
      end
   end

   // word assembly, first byte lands in the top byte lane
   generate
      if (WORD_BYTES == 1) begin : g_asm_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               asm_word <= '0;
            end else if (pack_en) begin
               asm_word <= rx_byte;
            end
         end
      end else begin : g_asm_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               asm_word <= '0;
            end else if (pack_en) begin
               asm_word <= {asm_word[WORD_W-BYTE_W-1:0], rx_byte};
            end
         end
      end
   endgenerate

   // transmit shifter
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh <= '0;
      end else if (load_en) begin
         tx_sh <= load_word;
      end else if (tx_shift) begin
         tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
      end
   end

   assign tx_msb = tx_sh[WORD_W-1];
   assign tx_nxt = tx_sh[WORD_W-2];

endmodule

// File: rtl/i2c_word_slave.sv
module i2c_word_slave
   import i2c_ws_pkg::*;
#(
   parameter logic [6:0]  DEV_ADDR    = 7'h2A,
   parameter int unsigned WORD_BYTES  = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         scl_i,
   input  logic                         sda_i,
   output logic                         scl_oe,
   output logic                         sda_oe,
   output logic                         busy_n,
   output logic [BYTE_W*WORD_BYTES-1:0] wr_word,
   output logic                         wr_valid,
   input  logic                         wr_ready,
   output logic                         rd_req,
   input  logic                         rd_ack,
   input  logic [BYTE_W*WORD_BYTES-1:0] rd_word
);

   localparam int unsigned WORD_W   = BYTE_W * WORD_BYTES;
   localparam int unsigned IDX_W    = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_BYTES - 1);

   generate
      if (WORD_BYTES < 1) begin : g_bad_word
         $error("i2c_word_slave: WORD_BYTES must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("i2c_word_slave: SYNC_STAGES must be at least 2");
      end
   endgenerate

   // ---------------- line synchronizers and bus conditions ----------------
   logic [1:0] ln_sync, ln_rise, ln_fall;
   logic       scl_s, scl_rise, scl_fall, sda_s;
   logic       start_det, stop_det;

   i2c_ws_sync #(
      .N_LINES (2),
      .STAGES  (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   ({sda_i, scl_i}),
      .sync  (ln_sync),
      .rise  (ln_rise),
      .fall  (ln_fall)
   );

   assign scl_s    = ln_sync[0];
   assign sda_s    = ln_sync[1];
   assign scl_rise = ln_rise[0];
   assign scl_fall = ln_fall[0];

   i2c_ws_cond u_cond (
      .scl_s     (scl_s),
      .sda_rise  (ln_rise[1]),
      .sda_fall  (ln_fall[1]),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   // ---------------- control state ----------------
   ws_state_e        state;
   logic [IDX_W-1:0] byte_idx;
   logic             rw_bit;
   logic             mst_ack;
   logic             quiet_st;

   logic [3:0]        bit_cnt;
   logic [BYTE_W-1:0] rx_byte;
   logic [WORD_W-1:0] asm_word;
   logic              tx_msb, tx_nxt;

   logic byte_done, in_ack, bus_active;
   logic dp_clr, dp_step, dp_pack, dp_load, dp_shift;

   assign byte_done  = (bit_cnt == 4'd8);
   assign in_ack     = (state == ST_ADDR_ACK) || (state == ST_WR_ACK) || (state == ST_RD_ACK);
   assign bus_active = (state != ST_IDLE) && (state != ST_IGNORE);

   assign dp_clr   = start_det | (scl_fall & (byte_done | in_ack));
   assign dp_step  = scl_rise & bus_active;
   assign dp_pack  = (state == ST_WR_BYTE) & scl_fall & byte_done;
   assign dp_load  = (state == ST_RD_FETCH) & rd_ack;
   assign dp_shift = (state == ST_RD_BYTE) & scl_fall & ~scl_oe;

   i2c_ws_datapath #(
      .WORD_BYTES (WORD_BYTES)
   ) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_clr   (dp_clr),
      .bit_step  (dp_step),
      .sda_bit   (sda_s),
      .pack_en   (dp_pack),
      .load_en   (dp_load),
      .load_word (rd_word),
      .tx_shift  (dp_shift),
      .bit_cnt   (bit_cnt),
      .rx_byte   (rx_byte),
      .asm_word  (asm_word),
      .tx_msb    (tx_msb),
      .tx_nxt    (tx_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         byte_idx <= '0;
         rw_bit   <= 1'b0;
         mst_ack  <= 1'b0;
         sda_oe   <= 1'b0;
         scl_oe   <= 1'b0;
         rd_req   <= 1'b0;
         wr_valid <= 1'b0;
      end else begin
         wr_valid <= 1'b0;
         if (start_det) begin
            state    <= ST_ADDR;
            byte_idx <= '0;
            sda_oe   <= 1'b0;
            scl_oe   <= 1'b0;
            rd_req   <= 1'b0;
         end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
            scl_oe <= 1'b0;
            rd_req <= 1'b0;
         end else begin
            unique case (state)
               ST_ADDR: begin
                  if (scl_fall && byte_done) begin
                     if (rx_byte[BYTE_W-1:1] == DEV_ADDR) begin
                        sda_oe <= 1'b1;
                        rw_bit <= rx_byte[0];
                        state  <= ST_ADDR_ACK;
                     end else begin
                        state  <= ST_IGNORE;
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (scl_fall) begin
                     sda_oe   <= 1'b0;
                     byte_idx <= '0;
                     if (rw_bit) begin
                        scl_oe <= 1'b1;
                        rd_req <= 1'b1;
                        state  <= ST_RD_FETCH;
                     end else begin
                        state  <= ST_WR_BYTE;
                     end
                  end
               end
               ST_WR_BYTE: begin
                  if (scl_fall && byte_done) begin
                     if (byte_idx == LAST_IDX) begin
                        byte_idx <= '0;
                        if (wr_ready) begin
                           wr_valid <= 1'b1;
                           sda_oe   <= 1'b1;
                           state    <= ST_WR_ACK;
                        end else begin
                           scl_oe   <= 1'b1;
                           state    <= ST_WR_WAIT;
                        end
                     end else begin
                        byte_idx <= byte_idx + 1'b1;
                        sda_oe   <= 1'b1;
                        state    <= ST_WR_ACK;
                     end
                  end
               end
               ST_WR_WAIT: begin
                  if (wr_ready) begin
                     wr_valid <= 1'b1;
                     sda_oe   <= 1'b1;
                     state    <= ST_WR_ACK;
                  end
               end
               ST_WR_ACK: begin
                  if (scl_oe) begin
                     scl_oe <= 1'b0;
                  end else if (scl_fall) begin
                     sda_oe <= 1'b0;
                     state  <= ST_WR_BYTE;
                  end
               end
               ST_RD_FETCH: begin
                  if (rd_ack) begin
                     rd_req <= 1'b0;
                     sda_oe <= ~rd_word[WORD_W-1];
                     state  <= ST_RD_BYTE;
                  end
               end
               ST_RD_BYTE: begin
                  if (scl_oe) begin
                     scl_oe <= 1'b0;
                  end else if (scl_fall) begin
                     if (byte_done) begin
                        sda_oe <= 1'b0;
                        state  <= ST_RD_ACK;
                     end else begin
                        sda_oe <= ~tx_nxt;
                     end
                  end
               end
               ST_RD_ACK: begin
                  if (scl_rise) begin
                     mst_ack <= ~sda_s;
                  end else if (scl_fall) begin
                     if (!mst_ack) begin
                        state <= ST_IGNORE;
                     end else if (byte_idx == LAST_IDX) begin
                        byte_idx <= '0;
                        scl_oe   <= 1'b1;
                        rd_req   <= 1'b1;
                        state    <= ST_RD_FETCH;
                     end else begin
                        byte_idx <= byte_idx + 1'b1;
                        sda_oe   <= ~tx_msb;
                        state    <= ST_RD_BYTE;
                     end
                  end
               end
               default: begin
               end
            endcase
         end
      end
   end

   assign busy_n   = ~((state == ST_WR_WAIT) || (state == ST_RD_FETCH));
   assign wr_word  = asm_word;
   assign quiet_st = (state == ST_IGNORE);

endmodule

// File: rtl/i2c_ws_chk.sv
module i2c_ws_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_s,
   input logic sda_oe,
   input logic scl_oe,
   input logic busy_n,
   input logic wr_valid,
   input logic rd_req,
   input logic rd_ack,
   input logic start_det,
   input logic stop_det,
   input logic quiet_st
);

   AST_WR_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |=> !wr_valid); // R3

   AST_BUSY_STRETCHES: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_n |-> scl_oe); // R5

   AST_FETCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_ack && !start_det && !stop_det) |=> rd_req); // R6

   AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      quiet_st |-> (!sda_oe && !scl_oe)); // R2

   AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (!sda_oe && !scl_oe && !rd_req)); // R9

   AST_SDA_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !$past(scl_s)); // R11

endmodule

bind i2c_word_slave i2c_ws_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_s     (scl_s),
   .sda_oe    (sda_oe),
   .scl_oe    (scl_oe),
   .busy_n    (busy_n),
   .wr_valid  (wr_valid),
   .rd_req    (rd_req),
   .rd_ack    (rd_ack),
   .start_det (start_det),
   .stop_det  (stop_det),
   .quiet_st  (quiet_st)
);

// File: tb/i2c_word_slave_tb.sv
module i2c_word_slave_tb;

   localparam int CLK_P = 10;
   localparam int Q     = 8;
   localparam int WDOG  = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        m_scl = 1'b1;
   logic        m_sda = 1'b1;
   logic        scl_line, sda_line;
   logic        scl_oe, sda_oe, busy_n, wr_valid, rd_req;
   logic        wr_ready = 1'b1;
   logic        rd_ack = 1'b0;
   logic [31:0] wr_word;
   logic [31:0] rd_word = '0;

   int total = 0;
   int bad   = 0;
   int wr_cnt = 0;
   logic [31:0] last_wr = '0;
   int rd_idx = 0;
   int rd_lat = 20;
   int rd_wait = 0;
   int stretch_viol = 0;
   logic [31:0] rd_mem [4];

   always #(CLK_P/2) clk = ~clk;

   assign scl_line = m_scl & ~scl_oe;
   assign sda_line = m_sda & ~sda_oe;

   i2c_word_slave u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_line),
      .sda_i    (sda_line),
      .scl_oe   (scl_oe),
      .sda_oe   (sda_oe),
      .busy_n   (busy_n),
      .wr_word  (wr_word),
      .wr_valid (wr_valid),
      .wr_ready (wr_ready),
      .rd_req   (rd_req),
      .rd_ack   (rd_ack),
      .rd_word  (rd_word)
   );

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic report();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   // write-strobe monitor and read-side responder
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (wr_valid) begin
            wr_cnt++;
            last_wr = wr_word;
         end
         if (rd_req && (scl_line || busy_n)) stretch_viol++;
         if (rd_ack) begin
            rd_ack = 1'b0;
         end else if (rd_req) begin
            if (rd_wait >= rd_lat) begin
               rd_ack  = 1'b1;
               rd_word = rd_mem[rd_idx % 4];
               rd_idx++;
               rd_wait = 0;
            end else begin
               rd_wait++;
            end
         end
      end
   end

   initial begin
      repeat (WDOG) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      report();
      $finish;
   end

   // ---------------- bus master model ----------------
   task automatic m_start();
      m_sda = 1'b1;
      cyc(Q);
      m_scl = 1'b1;
      wait (scl_line);
      cyc(Q);
      m_sda = 1'b0;
      cyc(Q);
      m_scl = 1'b0;
      cyc(Q);
   endtask

   task automatic m_stop();
      m_sda = 1'b0;
      cyc(Q);
      m_scl = 1'b1;
      wait (scl_line);
      cyc(Q);
      m_sda = 1'b1;
      cyc(2*Q);
   endtask

   task automatic m_wbyte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i];
         cyc(Q);
         m_scl = 1'b1;
         wait (scl_line);
         cyc(2*Q);
         m_scl = 1'b0;
         cyc(Q);
      end
      m_sda = 1'b1;
      cyc(Q);
      m_scl = 1'b1;
      wait (scl_line);
      cyc(Q);
      ack = (sda_line == 1'b0);
      cyc(Q);
      m_scl = 1'b0;
      cyc(Q);
   endtask

   task automatic m_rbyte(input bit give_ack, output logic [7:0] b);
      m_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         cyc(Q);
         m_scl = 1'b1;
         wait (scl_line);
         cyc(Q);
         b[i] = sda_line;
         cyc(Q);
         m_scl = 1'b0;
      end
      m_sda = give_ack ? 1'b0 : 1'b1;
      cyc(Q);
      m_scl = 1'b1;
      wait (scl_line);
      cyc(2*Q);
      m_scl = 1'b0;
      cyc(Q);
      m_sda = 1'b1;
   endtask

   task automatic m_wword(input logic [31:0] w, input string req, output int acks);
      bit a;
      acks = 0;
      for (int k = 3; k >= 0; k--) begin
         m_wbyte(w[8*k +: 8], a);
         if (a) acks++;
      end
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      chk("R12", "released lines / idle outputs after reset",
          {27'd0, scl_oe, sda_oe, busy_n, wr_valid, rd_req}, 32'b00100);
   endtask

   task automatic t_write_words();
      bit a;
      int acks, base;
      wr_ready = 1'b1;
      base = wr_cnt;
      m_start();
      m_wbyte(8'h54, a);
      chk("R1", "address 0x2A write acknowledged", {31'd0, a}, 32'd1);
      m_wword(32'hA1B2C3D4, "R4", acks);
      chk("R4", "acks for first word", acks, 4);
      chk("R3", "strobes after first word", wr_cnt - base, 1);
      chk("R3", "first word MSB-first", last_wr, 32'hA1B2C3D4);
      m_wword(32'h00FF55AA, "R4", acks);
      chk("R4", "acks for second word", acks, 4);
      chk("R3", "strobes after second word", wr_cnt - base, 2);
      chk("R3", "second word value", last_wr, 32'h00FF55AA);
      m_stop();
      cyc(4);
      chk("R9", "lines released after stop", {30'd0, scl_oe, sda_oe}, 32'd0);
   endtask

   task automatic t_write_busy();
      bit a;
      int base;
      base = wr_cnt;
      m_start();
      m_wbyte(8'h54, a);
      m_wbyte(8'h11, a);
      m_wbyte(8'h22, a);
      m_wbyte(8'h33, a);
      wr_ready = 1'b0;
      fork
         m_wbyte(8'h44, a);
         begin
            wait (busy_n == 1'b0);
            cyc(40);
            chk("R5", "ready line low while word pending", {31'd0, busy_n}, 32'd0);
            chk("R5", "clock held low while word pending", {31'd0, scl_line}, 32'd0);
            chk("R5", "no strobe while not ready", wr_cnt - base, 0);
            wr_ready = 1'b1;
            wait (busy_n == 1'b1);
            cyc(2);
            chk("R5", "strobe once ready rises", wr_cnt - base, 1);
         end
      join
      chk("R5", "fourth byte acknowledged after pause", {31'd0, a}, 32'd1);
      chk("R5", "paused word value", last_wr, 32'h11223344);
      m_stop();
   endtask

   task automatic t_mismatch();
      bit a;
      int acks, base;
      base = wr_cnt;
      m_start();
      m_wbyte(8'h56, a);
      chk("R2", "wrong address not acknowledged", {31'd0, a}, 32'd0);
      m_wword(32'h5A5A5A5A, "R2", acks);
      chk("R2", "data after wrong address not acknowledged", acks, 0);
      chk("R2", "no strobe after wrong address", wr_cnt - base, 0);
      m_stop();
   endtask

   task automatic t_repstart();
      bit a;
      int acks, base;
      base = wr_cnt;
      m_start();
      m_wbyte(8'h54, a);
      m_wbyte(8'hDE, a);
      m_wbyte(8'hAD, a);
      m_start();
      m_wbyte(8'h54, a);
      chk("R10", "address after repeated start acknowledged", {31'd0, a}, 32'd1);
      m_wword(32'h0C0FFEE0, "R10", acks);
      chk("R10", "one strobe after repeated start", wr_cnt - base, 1);
      chk("R10", "fresh word after repeated start", last_wr, 32'h0C0FFEE0);
      m_stop();
   endtask

   task automatic t_stop_partial();
      bit a;
      int acks, base;
      base = wr_cnt;
      m_start();
      m_wbyte(8'h54, a);
      m_wbyte(8'h99, a);
      m_stop();
      cyc(4);
      chk("R9", "partial word gives no strobe", wr_cnt - base, 0);
      m_start();
      m_wbyte(8'h54, a);
      m_wword(32'h01020304, "R9", acks);
      chk("R9", "word after stop excludes dropped byte", last_wr, 32'h01020304);
   endtask

   task automatic t_read_words();
      bit a;
      logic [7:0] b;
      logic [31:0] got0, got1;
      rd_mem[0] = 32'h8142C3A5;
      rd_mem[1] = 32'h7E00FF18;
      rd_idx = 0;
      rd_lat = 25;
      stretch_viol = 0;
      m_stop();
      m_start();
      m_wbyte(8'h55, a);
      chk("R1", "address 0x2A read acknowledged", {31'd0, a}, 32'd1);
      for (int k = 3; k >= 0; k--) begin
         m_rbyte(1'b1, b);
         got0[8*k +: 8] = b;
      end
      chk("R6", "first read word MSB-first", got0, 32'h8142C3A5);
      for (int k = 3; k >= 0; k--) begin
         m_rbyte(k != 0, b);
         got1[8*k +: 8] = b;
      end
      chk("R7", "second read word", got1, 32'h7E00FF18);
      chk("R6", "clock held and ready low during fetch", stretch_viol, 0);
      cyc(100);
      chk("R8", "no fetch after master nack", rd_idx, 2);
      chk("R8", "data line released after nack", {31'd0, sda_line}, 32'd1);
      m_stop();
   endtask

   task automatic t_read_early_nack();
      bit a;
      logic [7:0] b;
      rd_mem[0] = 32'hC33C0FF0;
      rd_idx = 0;
      rd_lat = 3;
      m_start();
      m_wbyte(8'h55, a);
      m_rbyte(1'b1, b);
      chk("R6", "byte 0 of short read", {24'd0, b}, 32'hC3);
      m_rbyte(1'b0, b);
      chk("R6", "byte 1 of short read", {24'd0, b}, 32'h3C);
      cyc(60);
      chk("R8", "single fetch for early nack", rd_idx, 1);
      chk("R8", "bus released after early nack", {30'd0, scl_oe, sda_oe}, 32'd0);
      m_stop();
   endtask

   initial begin
      cyc(5);
      rst_n = 1'b1;
      cyc(5);
      t_reset();
      t_write_words();
      t_write_busy();
      t_mismatch();
      t_repstart();
      t_stop_partial();
      t_read_words();
      t_read_early_nack();
      cyc(20);
      report();
      $finish;
   end

endmodule